// File: doc/BRIEF.md
# Wiper Position Register Control

This block keeps the two wiper position registers of a dual digital potentiometer whose settings live in the two bytes just above the user area of a 256-byte address space. A write sequencer presents a one-cycle committed-write strobe together with an address and a data byte once a write transaction has finished successfully. The block decides whether that write belongs to the 100-step wiper, the 256-step wiper, the user data area or the reserved top addresses. It then updates the matching wiper register, or raises a same-cycle write enable for the user memory, or does nothing.

A hardware write-protect input blocks every change while it is high, and that is its state when the pin is left open. The 100-step wiper stores the raw byte but drives a tap index clamped to 99. The 256-step wiper drives its full byte. During reset both registers load from the stored non-volatile bytes, so the taps are valid before any bus traffic. A read port returns the raw stored byte for either wiper address.

Top module: `wiper_ctrl`

## Requirements
- R1: While `rst_n` is low, on each clock edge the registers load from `nv_pot0_i` and `nv_pot1_i`. After release, `tap0_o` equals min(`nv_pot0_i`, 99) and `tap1_o` equals `nv_pot1_i`.
- R2: A commit to address F9h with `wp_i` low and data at or below 63h makes `tap0_o` equal the data from the cycle after the strobe.
- R3: A commit to F9h with data above 63h makes `tap0_o` read 99 (63h). `tap0_o` never exceeds 99.
- R4: A commit to address F8h with `wp_i` low makes `tap1_o` equal the data, over the whole range 00h to FFh, from the cycle after the strobe.
- R5: A commit to any address from FAh to FFh changes neither wiper and leaves `mem_we_o` low.
- R6: While `wp_i` is high, no commit changes either wiper and `mem_we_o` stays low.
- R7: Without `wr_commit_i`, neither wiper changes, whatever the address, data and `wp_i`.
- R8: `rd_data_o` gives the raw stored byte, unclamped, when `rd_addr_i` is F9h (100-step wiper) or F8h (256-step wiper), and 00h for every other address.
- R9: `mem_we_o` is high in the same cycle exactly when `wr_commit_i` is high, `wp_i` is low and `wr_addr_i` is at or below F7h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the stored bytes |
| wr_commit_i | input | 1 | One-cycle strobe for a committed write |
| wr_addr_i | input | 8 | Address of the committed write |
| wr_data_i | input | 8 | Data of the committed write |
| wp_i | input | 1 | Write protect, high blocks all writes |
| nv_pot0_i | input | 8 | Stored byte for the 100-step wiper |
| nv_pot1_i | input | 8 | Stored byte for the 256-step wiper |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Raw wiper byte, or 00h for other addresses |
| mem_we_o | output | 1 | Write enable for the user data area |
| tap0_o | output | 7 | Tap index of the 100-step wiper, 0 to 99 |
| tap1_o | output | 8 | Tap index of the 256-step wiper, 0 to 255 |

## Verification
The assertions assume that `wr_commit_i`, `wr_addr_i`, `wr_data_i` and `wp_i` are steady around each rising edge. They also assume that the stored bytes are valid for the whole time reset is asserted. The bench changes every input only at the falling edge. It holds the stored bytes constant through each reset pulse. Random stimulus favours the eight top addresses so that wiper, reserved and protected writes all occur often, and directed cases cover 63h, 64h, FFh and the F7h/FAh boundaries.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    typedef enum logic [1:0] {
        CLS_USER = 2'd0,
        CLS_POT0 = 2'd1,
        CLS_POT1 = 2'd2,
        CLS_RSV  = 2'd3
    } addr_cls_e;
endpackage

// File: rtl/wiper_decode.sv
module wiper_decode
    import wiper_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int POT0_ADDR = 'hF9,
    parameter int POT1_ADDR = 'hF8,
    parameter int USER_LAST = 'hF7
) (
    input  logic [ADDR_W-1:0] addr_i,
    output addr_cls_e         cls_o
);
    localparam logic [ADDR_W-1:0] A_POT0 = ADDR_W'(POT0_ADDR);
    localparam logic [ADDR_W-1:0] A_POT1 = ADDR_W'(POT1_ADDR);
    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(USER_LAST);

    always_comb begin
        if (addr_i <= A_LAST)       cls_o = CLS_USER;
        else if (addr_i == A_POT0)  cls_o = CLS_POT0;
        else if (addr_i == A_POT1)  cls_o = CLS_POT1;
        else                        cls_o = CLS_RSV;
    end
endmodule

// File: rtl/wiper_clamp.sv
module wiper_clamp #(
    parameter int IN_W  = 8,
    parameter int POS   = 100,
    parameter int OUT_W = (POS > 1) ? $clog2(POS) : 1
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [OUT_W-1:0] tap_o
);
    generate
        if (POS < (2 ** IN_W)) begin : g_clamp
            localparam logic [IN_W-1:0] TOP = IN_W'(POS - 1);
            always_comb begin
                if (raw_i > TOP) tap_o = OUT_W'(TOP);
                else             tap_o = OUT_W'(raw_i);
            end
            // R3: tap index stays within the legal positions
            always_comb begin
                p_tap_range_r3: assert (tap_o <= OUT_W'(TOP));
            end
        end else begin : g_pass
            assign tap_o = OUT_W'(raw_i);
        end
    endgenerate
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int POS0      = 100,
    parameter int POS1      = 256,
    parameter int POT0_ADDR = 'hF9,
    parameter int POT1_ADDR = 'hF8,
    parameter int USER_LAST = 'hF7,
    localparam int TAP0_W   = $clog2(POS0),
    localparam int TAP1_W   = $clog2(POS1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_commit_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wp_i,
    input  logic [DATA_W-1:0] nv_pot0_i,
    input  logic [DATA_W-1:0] nv_pot1_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              mem_we_o,
    output logic [TAP0_W-1:0] tap0_o,
    output logic [TAP1_W-1:0] tap1_o
);
    typedef struct packed {
        logic [DATA_W-1:0] pot0;
        logic [DATA_W-1:0] pot1;
    } wiper_state_t;

    wiper_state_t st_d, st_q;
    addr_cls_e    wr_cls, rd_cls;
    logic         wr_ok;

    wiper_decode #(
        .ADDR_W(ADDR_W), .POT0_ADDR(POT0_ADDR),
        .POT1_ADDR(POT1_ADDR), .USER_LAST(USER_LAST)
    ) u_wr_dec (.addr_i(wr_addr_i), .cls_o(wr_cls));

    wiper_decode #(
        .ADDR_W(ADDR_W), .POT0_ADDR(POT0_ADDR),
        .POT1_ADDR(POT1_ADDR), .USER_LAST(USER_LAST)
    ) u_rd_dec (.addr_i(rd_addr_i), .cls_o(rd_cls));

    assign wr_ok = wr_commit_i && !wp_i;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (wr_cls)
                CLS_POT0: st_d.pot0 = wr_data_i;
                CLS_POT1: st_d.pot1 = wr_data_i;
                default:  ;
            endcase
        end
        if (!rst_n) begin
            st_d.pot0 = nv_pot0_i;
            st_d.pot1 = nv_pot1_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_we_o = wr_ok && (wr_cls == CLS_USER);

    always_comb begin
        case (rd_cls)
            CLS_POT0: rd_data_o = st_q.pot0;
            CLS_POT1: rd_data_o = st_q.pot1;
            default:  rd_data_o = '0;
        endcase
    end

    wiper_clamp #(.IN_W(DATA_W), .POS(POS0), .OUT_W(TAP0_W))
        u_clamp0 (.raw_i(st_q.pot0), .tap_o(tap0_o));
    wiper_clamp #(.IN_W(DATA_W), .POS(POS1), .OUT_W(TAP1_W))
        u_clamp1 (.raw_i(st_q.pot1), .tap_o(tap1_o));

    p_wp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_i && wp_i) |=> ($stable(st_q.pot0) && $stable(st_q.pot1)));

    p_rsv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_i && wr_addr_i > ADDR_W'(USER_LAST)
         && wr_addr_i != ADDR_W'(POT0_ADDR) && wr_addr_i != ADDR_W'(POT1_ADDR))
        |=> ($stable(st_q.pot0) && $stable(st_q.pot1)));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit_i |=> ($stable(st_q.pot0) && $stable(st_q.pot1)));

    p_pot0_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_i && !wp_i && wr_addr_i == ADDR_W'(POT0_ADDR))
        |=> (st_q.pot0 == $past(wr_data_i)));

    p_pot1_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_i && !wp_i && wr_addr_i == ADDR_W'(POT1_ADDR))
        |=> (tap1_o == TAP1_W'($past(wr_data_i))));

    p_memwe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (wr_commit_i && !wp_i && wr_addr_i <= ADDR_W'(USER_LAST)));
endmodule

// File: tb/wiper_ctrl_bench.sv
module wiper_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_commit_i;
    logic [7:0] wr_addr_i, wr_data_i, nv_pot0_i, nv_pot1_i, rd_addr_i;
    logic       wp_i;
    logic [7:0] rd_data_o;
    logic       mem_we_o;
    logic [6:0] tap0_o;
    logic [7:0] tap1_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_pot0, m_pot1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wiper_ctrl u_wiper_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_commit_i(wr_commit_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .wp_i(wp_i),
        .nv_pot0_i(nv_pot0_i), .nv_pot1_i(nv_pot1_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .mem_we_o(mem_we_o),
        .tap0_o(tap0_o), .tap1_o(tap1_o)
    );

    function automatic logic [6:0] exp_tap0(input logic [7:0] raw);
        return (raw > 8'h63) ? 7'd99 : raw[6:0];
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'hF9) return m_pot0;
        if (a == 8'hF8) return m_pot1;
        return 8'h00;
    endfunction

    function automatic logic exp_we(input logic c, input logic w, input logic [7:0] a);
        return c && !w && (a <= 8'hF7);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_taps(input string req);
        chk(tap0_o == exp_tap0(m_pot0), {req, " tap0"}, tap0_o, exp_tap0(m_pot0));
        chk(tap1_o == m_pot1, {req, " tap1"}, tap1_o, m_pot1);
    endtask

    // Drive one cycle at negedge; check mem_we in cycle, taps after the edge.
    task automatic op(input logic c, input logic w, input logic [7:0] a,
                      input logic [7:0] d, input logic [7:0] ra, input string req);
        @(negedge clk);
        wr_commit_i = c; wp_i = w; wr_addr_i = a; wr_data_i = d; rd_addr_i = ra;
        #1;
        chk(mem_we_o == exp_we(c, w, a), {req, " R9 mem_we"}, mem_we_o, exp_we(c, w, a));
        chk(rd_data_o == exp_rd(ra), {req, " R8 rd_data"}, rd_data_o, exp_rd(ra));
        if (c && !w && a == 8'hF9) m_pot0 = d;
        if (c && !w && a == 8'hF8) m_pot1 = d;
        @(negedge clk);
        wr_commit_i = 1'b0;
        #1;
        check_taps(req);
        chk(rd_data_o == exp_rd(ra), {req, " R8 rd_after"}, rd_data_o, exp_rd(ra));
    endtask

    task automatic do_reset(input logic [7:0] n0, input logic [7:0] n1);
        @(negedge clk);
        rst_n = 1'b0; nv_pot0_i = n0; nv_pot1_i = n1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pot0 = n0; m_pot1 = n1;
        #1;
        check_taps("R1 reset load");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] a, d, ra;
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; wr_commit_i = 1'b0; wp_i = 1'b1;
        wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
        nv_pot0_i = '0; nv_pot1_i = '0;

        do_reset(8'h2A, 8'hC3);
        do_reset(8'hF0, 8'h00);                           // R1 clamp of stored byte
        op(1, 0, 8'hF9, 8'h63, 8'hF9, "R2 top legal");
        op(1, 0, 8'hF9, 8'h00, 8'hF9, "R2 zero");
        op(1, 0, 8'hF9, 8'h64, 8'hF9, "R3 just above");
        op(1, 0, 8'hF9, 8'hFF, 8'hF9, "R3 max raw");       // R8 raw FF read back
        op(1, 0, 8'hF8, 8'hFF, 8'hF8, "R4 full");
        op(1, 0, 8'hF8, 8'h00, 8'hF8, "R4 zero");
        op(1, 0, 8'hFA, 8'h11, 8'hFA, "R5 reserved low");
        op(1, 0, 8'hFF, 8'h22, 8'hF9, "R5 reserved high");
        op(1, 1, 8'hF9, 8'h05, 8'hF9, "R6 protected pot0");
        op(1, 1, 8'hF8, 8'h77, 8'hF8, "R6 protected pot1");
        op(1, 1, 8'h10, 8'h77, 8'h10, "R6 protected user");
        op(1, 0, 8'hF7, 8'h33, 8'h00, "R9 user last");
        op(0, 0, 8'hF9, 8'h12, 8'hF9, "R7 no strobe");
        op(0, 0, 8'hF8, 8'h34, 8'hF8, "R7 no strobe pot1");

        for (int i = 0; i < 400; i++) begin
            a  = ($urandom % 10 < 7) ? (8'hF8 + 8'($urandom % 8)) : 8'($urandom);
            d  = 8'($urandom);
            ra = ($urandom % 2 == 0) ? (8'hF8 + 8'($urandom % 8)) : 8'($urandom);
            op(($urandom % 5) != 0, ($urandom % 4) == 0, a, d, ra, "R2-random");
        end

        do_reset(8'h63, 8'h80);
        op(1, 0, 8'hF8, 8'h5A, 8'hF8, "R4 after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule